// File: doc/BRIEF.md
# Deferred-Write Parallel EEPROM Model

This block models a byte-wide parallel EEPROM placed in a window of a 16-bit processor address space. Reads that hit the window return the stored byte, just as RAM would. A write that hits the window is not applied at once. The block records the address and the data, raises `busy` and starts a programming interval of fixed length. The byte reaches the array only when that interval has elapsed.

While the interval runs, software can detect completion by toggle polling. Each read of the pending address returns the written byte with one status bit flipped relative to the previous poll read. A read of any other address inside the window abandons the pending write. A second write inside the window replaces the first one and restarts the interval.

Accesses outside the window do not affect the model. They go unchanged to a backing-memory port, so the model can be placed in front of an ordinary system memory.

Top module: `eeprom_wmodel`

## Requirements
- R1: An address is in the window when `WIN_BASE <= bus_addr < WIN_BASE + WIN_SIZE` (defaults 0x2000 and 0x0800). For an access outside the window, `ext_rd`, `ext_wr`, `ext_addr` and `ext_wdata` copy the bus in the same cycle, and the backing read data shows on `bus_rdata` one cycle after the read strobe. An access inside the window never strobes the backing port.
- R2: While no write is pending, a read inside the window returns the stored byte on `bus_rdata` one cycle after `bus_rd`. The array holds all zeros at power-up.
- R3: A write inside the window raises `busy` after that clock edge. `busy` stays high for exactly `BUSY_CYCLES` cycles (default 80000, which is 10 ms at 8 MHz). The array is not changed when the write is accepted.
- R4: When the interval ends, the recorded byte is stored at the recorded address and `busy` falls.
- R5: While busy, each read of the pending address returns a polling value. The first poll returns the written byte. Each later poll returns the previous poll value with bit `POLL_BIT` (default 6) inverted.
- R6: While busy, a read of a different address inside the window cancels the pending write and lowers `busy` after that edge. That read returns the stored byte, and the cancelled byte is never committed.
- R7: A write inside the window while busy discards the earlier pending write. It records the new address and data and restarts the full interval.
- R8: An access in the same cycle in which the interval ends sees the byte already committed. A read of that address returns the stored byte, not a poll value.
- R9: An active-low `rst_n` (asserted at once, released through two flops) clears `busy` and any pending write. It leaves the array contents unchanged.
- R10: Accesses outside the window while busy neither cancel nor restart the pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, wins over `bus_rd` |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| busy | output | 1 | A write is being programmed |
| ext_rd | output | 1 | Backing-memory read strobe |
| ext_wr | output | 1 | Backing-memory write strobe |
| ext_addr | output | 16 | Backing-memory address |
| ext_wdata | output | 8 | Backing-memory write data |
| ext_rdata | input | 8 | Backing-memory read data, one cycle after `ext_rd` |

## Verification
If the interval counter is off by one, `busy` falls one cycle early or late. A read issued in the final cycle then returns a poll value where the committed byte was expected. If the pending address or data is corrupted, the fault shows at the first poll read or at the first read after expiry, because the wrong byte appears or the wrong location changes. If the cancel or restart logic is wrong, an abandoned byte appears in the array on a later read. It can also show as `busy` staying high when it should have dropped, visible within the next `BUSY_CYCLES` cycles.

// File: rtl/eewm_pkg.sv
package eewm_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/eewm_window.sv
module eewm_window
  import eewm_pkg::*;
#(
  parameter int unsigned BASE  = 32'h2000,
  parameter int unsigned SIZE  = 32'h0800,
  parameter int unsigned OFF_W = 11
) (
  input  addr_t            addr,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SIZE);

  logic [ADDR_W:0] a_wide;

  always_comb begin
    a_wide = {1'b0, addr};
    hit    = (a_wide >= LO) && (a_wide < HI);
    off    = OFF_W'(addr - ADDR_W'(BASE));
  end
endmodule

// File: rtl/eewm_timer.sv
module eewm_timer #(
  parameter int unsigned CYCLES = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = busy_q && (cnt_q == LAST);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (expire || cancel) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST)); // R3

  AST_EXPIRY_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !busy_q); // R4

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0)); // R7
endmodule

// File: rtl/eewm_array.sv
module eewm_array
  import eewm_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned OFF_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] waddr,
  input  byte_t            wdata,
  input  logic [OFF_W-1:0] raddr,
  output byte_t            rdata
);
  byte_t cells [DEPTH] = '{default: '0};

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_wmodel.sv
module eeprom_wmodel
  import eewm_pkg::*;
#(
  parameter int unsigned WIN_BASE    = 32'h2000,
  parameter int unsigned WIN_SIZE    = 32'h0800,
  parameter int unsigned BUSY_CYCLES = 80000,
  parameter int unsigned POLL_BIT    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        ext_rd,
  output logic        ext_wr,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata
);
  localparam int unsigned OFF_W = $clog2(WIN_SIZE);
  localparam byte_t POLL_MASK = byte_t'(1) << POLL_BIT;

  // reset: assert asynchronously, release through two flops
  logic [1:0] rst_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  logic             in_win;
  logic [OFF_W-1:0] off;

  eewm_window #(.BASE(WIN_BASE), .SIZE(WIN_SIZE), .OFF_W(OFF_W)) u_win (
    .addr (bus_addr),
    .hit  (in_win),
    .off  (off)
  );

  logic tmr_busy, expire, start, cancel;

  eewm_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start),
    .cancel (cancel),
    .busy   (tmr_busy),
    .expire (expire)
  );

  logic [OFF_W-1:0] pend_off_q, pend_off_d;
  byte_t            pend_data_q, pend_data_d;
  byte_t            poll_q, poll_d;
  byte_t            rd_q, rd_d;
  logic             ext_sel_q, ext_sel_d;
  byte_t            arr_rdata, arr_byp;

  eewm_array #(.DEPTH(WIN_SIZE), .OFF_W(OFF_W)) u_arr (
    .clk   (clk),
    .we    (expire),
    .waddr (pend_off_q),
    .wdata (pend_data_q),
    .raddr (off),
    .rdata (arr_rdata)
  );

  logic wr_win, rd_win, live, poll_hit;

  always_comb begin
    wr_win   = bus_wr && in_win;
    rd_win   = bus_rd && !bus_wr && in_win;
    live     = tmr_busy && !expire;
    start    = wr_win;
    poll_hit = rd_win && live && (off == pend_off_q);
    cancel   = rd_win && live && (off != pend_off_q);
    // a byte committed at this edge is already visible to this read
    arr_byp  = (expire && off == pend_off_q) ? pend_data_q : arr_rdata;

    pend_off_d  = pend_off_q;
    pend_data_d = pend_data_q;
    poll_d      = poll_q;
    if (start) begin
      pend_off_d  = off;
      pend_data_d = bus_wdata;
      poll_d      = bus_wdata;
    end else if (poll_hit) begin
      poll_d = poll_q ^ POLL_MASK;
    end

    rd_d = rd_q;
    if (poll_hit)    rd_d = poll_q;
    else if (rd_win) rd_d = arr_byp;

    ext_sel_d = ext_sel_q;
    if (bus_rd && !bus_wr) ext_sel_d = !in_win;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_off_q  <= '0;
      pend_data_q <= '0;
      poll_q      <= '0;
      rd_q        <= '0;
      ext_sel_q   <= 1'b0;
    end else begin
      pend_off_q  <= pend_off_d;
      pend_data_q <= pend_data_d;
      poll_q      <= poll_d;
      rd_q        <= rd_d;
      ext_sel_q   <= ext_sel_d;
    end
  end

  always_comb begin
    ext_rd    = bus_rd && !bus_wr && !in_win;
    ext_wr    = bus_wr && !in_win;
    ext_addr  = bus_addr;
    ext_wdata = bus_wdata;
    bus_rdata = ext_sel_q ? ext_rdata : rd_q;
    busy      = tmr_busy;
  end

  AST_WRITE_ARMS_BUSY: assert property (@(posedge clk) disable iff (!srst_n)
    wr_win |=> busy); // R3

  AST_STRAY_READ_CANCELS: assert property (@(posedge clk) disable iff (!srst_n)
    cancel |=> !busy); // R6

  AST_POLL_FLIPS_BIT: assert property (@(posedge clk) disable iff (!srst_n)
    poll_hit |=> (poll_q == ($past(poll_q) ^ POLL_MASK))); // R5

  AST_OUTSIDE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!srst_n)
    (live && !in_win && (bus_rd || bus_wr)) |=> (busy && $stable(pend_off_q) && $stable(pend_data_q))); // R10
endmodule

// File: tb/eeprom_wmodel_test.sv
module eeprom_wmodel_test;
  localparam int unsigned BASE = 32'h2000;
  localparam int unsigned SIZE = 32'h0800;
  localparam int unsigned N    = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        busy, ext_rd, ext_wr;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  eeprom_wmodel #(.WIN_BASE(BASE), .WIN_SIZE(SIZE), .BUSY_CYCLES(N), .POLL_BIT(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // backing memory behind the pass-through port
  logic [7:0] ext_mem [int];
  always @(posedge clk) begin
    if (ext_wr) ext_mem[int'(ext_addr)] = ext_wdata;
    if (ext_rd) ext_rdata <= ext_mem.exists(int'(ext_addr)) ? ext_mem[int'(ext_addr)] : 8'h00;
  end

  // reference state
  logic [7:0] shadow [SIZE];
  logic [7:0] ext_exp [int];
  bit         m_busy;
  int         m_cnt, m_off;
  logic [7:0] m_data, m_poll;

  function automatic bit in_win(input logic [15:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + SIZE);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input bit rd, input bit wr, input logic [15:0] a,
                            input logic [7:0] d, output logic [7:0] exp);
    bit inw = in_win(a);
    int off = int'(a) - BASE;
    exp = 8'h00;
    if (m_busy && m_cnt == N - 1) begin
      shadow[m_off] = m_data;
      m_busy = 0;
      m_cnt  = 0;
    end else if (m_busy) begin
      m_cnt++;
    end
    if (wr) begin
      if (inw) begin
        m_busy = 1; m_cnt = 0; m_off = off; m_data = d; m_poll = d;
      end else begin
        ext_exp[int'(a)] = d;
      end
    end else if (rd) begin
      if (!inw) begin
        exp = ext_exp.exists(int'(a)) ? ext_exp[int'(a)] : 8'h00;
      end else if (m_busy && off == m_off) begin
        exp = m_poll;
        m_poll ^= 8'h40;
      end else begin
        if (m_busy) begin m_busy = 0; m_cnt = 0; end
        exp = shadow[off];
      end
    end
  endtask

  // one bus cycle, called at a falling edge
  task automatic tick(input bit rd, input bit wr, input logic [15:0] a,
                      input logic [7:0] d, input string tag);
    logic [7:0] exp;
    bit inw;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    inw = in_win(a);
    if (rd || wr) begin
      chk((ext_rd == (rd && !wr && !inw)) && (ext_wr == (wr && !inw)) &&
          (inw || (ext_addr == a && ext_wdata == d)), "R1 port routing",
          {ext_rd, ext_wr}, {(rd && !wr && !inw), (wr && !inw)});
    end
    @(posedge clk);
    model_edge(rd, wr, a, d, exp);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    if (rd && !wr) chk(bus_rdata == exp, tag, bus_rdata, exp);
    chk(busy == m_busy, tag, busy, m_busy);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 16'h0000, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_busy = 0; m_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    for (int i = 0; i < int'(SIZE); i++) shadow[i] = 8'h00;
    m_busy = 0; m_cnt = 0; m_off = 0; m_data = 0; m_poll = 0;
    do_reset();

    // R9: reset state
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    // R2: array starts at zero, read data one cycle later
    tick(1, 0, 16'h2005, 8'h00, "R2 zero init");

    // R3 / R5: write then poll the same address
    tick(0, 1, 16'h2005, 8'hA5, "R3 write arms busy");
    tick(1, 0, 16'h2005, 8'h00, "R5 first poll");
    tick(1, 0, 16'h2005, 8'h00, "R5 second poll");
    tick(1, 0, 16'h2005, 8'h00, "R5 third poll");
    idle(N, "R4 busy window");
    tick(1, 0, 16'h2005, 8'h00, "R4 committed byte");

    // R6: stray in-window read cancels
    tick(0, 1, 16'h2006, 8'h3C, "R3 write");
    tick(1, 0, 16'h2007, 8'h00, "R6 stray read");
    idle(N + 2, "R6 no busy");
    tick(1, 0, 16'h2006, 8'h00, "R6 not committed");

    // R7: second write restarts the interval
    tick(0, 1, 16'h2008, 8'h11, "R7 first write");
    idle(10, "R7 busy");
    tick(0, 1, 16'h2009, 8'h22, "R7 second write");
    idle(N + 3, "R7 restarted interval");
    tick(1, 0, 16'h2008, 8'h00, "R7 first write dropped");
    tick(1, 0, 16'h2009, 8'h00, "R7 second write stored");

    // R8: read in the expiry cycle sees committed byte, not poll value
    tick(0, 1, 16'h200A, 8'h77, "R8 write");
    tick(1, 0, 16'h200A, 8'h00, "R8 poll");
    idle(N - 2, "R8 busy");
    tick(1, 0, 16'h200A, 8'h00, "R8 read at expiry");
    // R8: write in the expiry cycle keeps the earlier commit
    tick(0, 1, 16'h200B, 8'h5E, "R8 write");
    idle(N - 1, "R8 busy");
    tick(0, 1, 16'h200C, 8'h81, "R8 write at expiry");
    idle(N + 1, "R8 second interval");
    tick(1, 0, 16'h200B, 8'h00, "R8 first commit kept");
    tick(1, 0, 16'h200C, 8'h00, "R8 second commit");

    // R9: reset mid-interval drops pending write, keeps array
    tick(0, 1, 16'h200D, 8'h5A, "R9 write");
    idle(3, "R9 busy");
    do_reset();
    chk(busy == 1'b0, "R9 busy cleared", busy, 0);
    idle(N + 2, "R9 idle");
    tick(1, 0, 16'h200D, 8'h00, "R9 write dropped");
    tick(1, 0, 16'h2005, 8'h00, "R9 array kept");

    // R1: window edges
    tick(0, 1, 16'h1FFF, 8'h9C, "R1 below window");
    tick(1, 0, 16'h1FFF, 8'h00, "R1 below window read");
    tick(0, 1, 16'h2800, 8'h4D, "R1 above window");
    tick(1, 0, 16'h2800, 8'h00, "R1 above window read");
    tick(0, 1, 16'h27FF, 8'h66, "R1 last in-window byte");
    idle(N, "R1 busy");
    tick(1, 0, 16'h27FF, 8'h00, "R1 last in-window read");

    // R10: outside traffic while busy
    tick(0, 1, 16'h2010, 8'hC3, "R10 write");
    tick(1, 0, 16'h8000, 8'h00, "R10 outside read");
    tick(0, 1, 16'h8001, 8'h19, "R10 outside write");
    tick(1, 0, 16'h8001, 8'h00, "R10 outside readback");
    idle(N, "R10 busy kept");
    tick(1, 0, 16'h2010, 8'h00, "R10 committed");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      logic [15:0] ia = 16'(BASE + ($urandom % 8));
      logic [15:0] oa = 16'(16'h8000 + ($urandom % 8));
      logic [7:0]  dv = 8'($urandom);
      if (r < 20)      tick(0, 1, ia, dv, "R3/R7 random write");
      else if (r < 55) tick(1, 0, ia, 8'h00, "R2/R5/R6 random read");
      else if (r < 65) tick(0, 1, oa, dv, "R10 random outside write");
      else if (r < 75) tick(1, 0, oa, 8'h00, "R10 random outside read");
      else             idle(int'($urandom % 50), "R4 random idle");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule